// File: doc/BRIEF.md
# One-Hot 5-2-1 Sweep Multiplier Selector

This block picks the sweep-rate multiplier (1, 2 or 5) inside the timing decade chosen by a decade counter downstream. It holds its choice as a three-bit one-hot state. In seek mode a seek-start pulse loads the "5" state. Each advance pulse after that steps the state downward, 5 to 2 to 1 and back to 5. Each wrap from 1 to 5 issues a one-cycle carry strobe that advances the decade counter, so three advance pulses produce one carry.

In external mode three program lines select the state directly. The selection holds for as long as the line stays asserted, and seek-start and advance pulses are ignored. In manual mode the counter is disabled: all multiplier lines go inactive and no carry is produced.

Top module: `mult_sel_top`

## Requirements
- R1: After synchronous active-low reset, the state is "5" (`mult_o` = 3'b100), and `carry_o` is 0.
- R2: `mult_o` bit 0 means multiplier 1, bit 1 means 2 and bit 2 means 5. In seek and external modes exactly one bit is set.
- R3: In seek mode (`mode_i` = 2'b00), a `seek_start_i` high at a clock edge loads "5" on that edge and produces no carry.
- R4: In seek mode, an `advance_i` high at an edge, with `seek_start_i` low, moves 5 to 2, 2 to 1 and 1 to 5. Stepping repeats for every advance.
- R5: `carry_o` is high for exactly the one cycle after the edge at which the state moves from 1 to 5, which gives one carry per three advances. No other transition raises it.
- R6: When `seek_start_i` and `advance_i` are both high at the same edge, the state becomes "5" with no carry.
- R7: In external mode (`mode_i` = 2'b01), an asserted `prog_i` line loads its state at the next edge. `prog_i` bit 0 selects 1, bit 1 selects 2 and bit 2 selects 5. No carry is produced, and `advance_i` and `seek_start_i` have no effect.
- R8: In external mode, when several `prog_i` lines are high, 1 wins over 2, and 2 wins over 5. When no line is high, the last state is held.
- R9: In manual mode (`mode_i` = 2'b10 or 2'b11), `mult_o` is 3'b000 and `carry_o` is 0. On leaving manual mode the counter resumes from its stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seek_start_i | input | 1 | Seek-cycle start pulse, presets "5" |
| advance_i | input | 1 | Advance pulse, steps the state |
| mode_i | input | 2 | 00 seek, 01 external, 1x manual |
| prog_i | input | 3 | External select: bit0=1, bit1=2, bit2=5 |
| mult_o | output | 3 | One-hot multiplier: bit0=1, bit1=2, bit2=5 |
| carry_o | output | 1 | One-cycle carry to the decade counter |

## Verification
The two functions that can land in the same clock are the seek-start preset and the advance step. The bench first walks the state to "1", where an advance on its own would wrap and raise a carry. It then drives both pulses high for the same edge. The result is judged correct only if the state reads "5" and `carry_o` stays low in the following cycle.

// File: rtl/mult_sel_pkg.sv
// Package: shared mode encoding and state width for the multiplier selector.
// Assumes: mode_i codes 00 seek, 01 external, 1x manual.
package mult_sel_pkg;
    localparam int unsigned N_STATES = 3;
    typedef enum logic [1:0] {
        MODE_SEEK   = 2'b00,
        MODE_EXT    = 2'b01,
        MODE_MAN    = 2'b10,
        MODE_MAN_B  = 2'b11
    } mode_t;
endpackage

// File: rtl/mult_sel_prio.sv
// Module: picks one external program line, with the lowest bit winning.
// Assumes: bit order is 1, 2, 5. The output is one-hot, or zero when no line is high.
module mult_sel_prio #(
    parameter int unsigned W = 3
) (
    input  logic [W-1:0] req_i,
    output logic [W-1:0] gnt_o,
    output logic         any_o
);
    // Lowest-index-first priority pick
    always_comb begin
        gnt_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) gnt_o = '0;
            if (req_i[i]) gnt_o[i] = 1'b1;
        end
    end

    // Flag that any request is present
    always_comb any_o = |req_i;

    always_comb begin
        if (any_o) a_prio_onehot_r8: assert ($onehot(gnt_o));
    end
endmodule

// File: rtl/mult_sel_ring.sv
// Module: one-hot down-ring (5->2->1->5) with preset, load and a registered carry.
// Assumes: the caller resolves priority. At most one of preset/step/load acts per edge,
// and preset wins.
module mult_sel_ring #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         preset_i,
    input  logic         step_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] state_o,
    output logic         carry_o
);
    localparam logic [W-1:0] TOP = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] nxt;
    logic         wrap;

    // Next-state choice: preset, then load, then downward rotate
    always_comb begin
        nxt  = state_o;
        wrap = 1'b0;
        if (preset_i) begin
            nxt = TOP;
        end else if (load_i) begin
            nxt = load_val_i;
        end else if (step_i) begin
            nxt  = {state_o[0], state_o[W-1:1]};
            wrap = state_o[0];
        end
    end

    // State and carry registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o <= TOP;
            carry_o <= 1'b0;
        end else begin
            state_o <= nxt;
            carry_o <= wrap;
        end
    end

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state_o));
    p_preset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        preset_i |=> (state_o == TOP) && !carry_o);
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !preset_i && !load_i) |=> state_o == {$past(state_o[0]), $past(state_o[W-1:1])});
    p_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |-> ($past(state_o[0]) && state_o == TOP));
endmodule

// File: rtl/mult_sel_top.sv
// Module: sweep multiplier selector. It decodes the mode and drives the ring from
// seek pulses or external program lines, and it blanks the outputs in manual mode.
// Assumes: the inputs are synchronous to clk, and the pulses are one cycle or longer
// (each high edge acts).
module mult_sel_top
    import mult_sel_pkg::*;
#(
    parameter int unsigned W = N_STATES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         seek_start_i,
    input  logic         advance_i,
    input  logic [1:0]   mode_i,
    input  logic [W-1:0] prog_i,
    output logic [W-1:0] mult_o,
    output logic         carry_o
);
    logic         is_seek, is_ext, is_man;
    logic [W-1:0] prog_gnt, ring_state;
    logic         prog_any, ring_carry;

    // Mode decode
    always_comb begin
        is_seek = (mode_i == MODE_SEEK);
        is_ext  = (mode_i == MODE_EXT);
        is_man  = mode_i[1];
    end

    mult_sel_prio #(.W(W)) i_prio (
        .req_i (prog_i),
        .gnt_o (prog_gnt),
        .any_o (prog_any)
    );

    mult_sel_ring #(.W(W)) i_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .preset_i   (is_seek && seek_start_i),
        .step_i     (is_seek && advance_i),
        .load_i     (is_ext && prog_any),
        .load_val_i (prog_gnt),
        .state_o    (ring_state),
        .carry_o    (ring_carry)
    );

    // Output gating in manual mode
    always_comb begin
        mult_o  = is_man ? '0 : ring_state;
        carry_o = is_man ? 1'b0 : ring_carry;
    end

    p_manual_r9: assert property (@(posedge clk) disable iff (!rst_n)
        is_man |-> (mult_o == '0) && !carry_o);
    p_ext_nocarry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_ext |=> !carry_o);
endmodule

// File: tb/test_mult_sel_top.sv
module test_mult_sel_top;
    logic       clk = 0, rst_n = 0, ss = 0, adv = 0;
    logic [1:0] mode = 2'b00;
    logic [2:0] prog = 3'b000;
    logic [2:0] mult;
    logic       carry;
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    mult_sel_top i_mult_sel_top (
        .clk(clk), .rst_n(rst_n), .seek_start_i(ss), .advance_i(adv),
        .mode_i(mode), .prog_i(prog), .mult_o(mult), .carry_o(carry)
    );

    task automatic chk(input string req, input logic [2:0] em, input logic ec);
        n_chk++;
        if (mult !== em || carry !== ec) begin
            n_bad++;
            $display("FAIL %s: mult=%b carry=%b expected mult=%b carry=%b", req, mult, carry, em, ec);
        end
    endtask

    // one edge with the given pulses, then sample away from the edge
    task automatic cyc(input logic s, input logic a);
        ss = s; adv = a;
        @(posedge clk); #5;
        ss = 0; adv = 0;
    endtask

    task automatic t_reset;
        rst_n = 0; mode = 2'b00; prog = 0;
        repeat (2) @(posedge clk); #5;
        rst_n = 1;
        chk("R1", 3'b100, 0);
    endtask

    task automatic t_seek_walk;
        cyc(0, 1); chk("R4", 3'b010, 0);
        cyc(0, 1); chk("R4", 3'b001, 0);
        cyc(0, 1); chk("R5", 3'b100, 1);
        cyc(0, 0); chk("R5", 3'b100, 0);
        for (int k = 0; k < 6; k++) cyc(0, 1);
        chk("R4", 3'b100, 1);
    endtask

    task automatic t_preset;
        cyc(0, 1); chk("R4", 3'b010, 0);
        cyc(1, 0); chk("R3", 3'b100, 0);
        cyc(0, 1); cyc(0, 1); chk("R2", 3'b001, 0);
        cyc(1, 1); chk("R6", 3'b100, 0);
        cyc(0, 0); chk("R6", 3'b100, 0);
    endtask

    task automatic t_external;
        mode = 2'b01; prog = 3'b010;
        cyc(0, 0); chk("R7", 3'b010, 0);
        prog = 3'b000;
        cyc(0, 1); chk("R7", 3'b010, 0);
        cyc(1, 0); chk("R8", 3'b010, 0);
        prog = 3'b111; cyc(0, 0); chk("R8", 3'b001, 0);
        prog = 3'b110; cyc(0, 0); chk("R8", 3'b010, 0);
        prog = 3'b100; cyc(0, 0); chk("R7", 3'b100, 0);
        prog = 3'b001; cyc(0, 0); chk("R7", 3'b001, 0);
        prog = 3'b000; mode = 2'b00;
    endtask

    task automatic t_manual;
        // stored state is 1
        mode = 2'b10; cyc(0, 1); chk("R9", 3'b000, 0);
        mode = 2'b11; cyc(1, 1); chk("R9", 3'b000, 0);
        mode = 2'b00; #1; chk("R9", 3'b001, 0);
        cyc(0, 1); chk("R5", 3'b100, 1);
    endtask

    initial begin
        #5;
        t_reset();
        t_seek_walk();
        t_preset();
        t_external();
        t_manual();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule